// File: doc/BRIEF.md
# Microsecond Timebase with Rational Prescaler

This block keeps a free-running microsecond count for boot code and drivers that need short, calibrated waits. A rate generator runs from the reference oscillator clock and gives a single-cycle advance pulse at an average rate of dividend/divisor times the oscillator rate. Software picks both numbers so that the pulse rate comes to 1 MHz. Because the ratio is rational rather than a whole divide factor, oscillators such as 19.2 MHz still give an exact long-term microsecond rate.

The count wraps without saturating. Software takes elapsed time as the modular difference of two reads, so a wait stays correct across the wrap point. Access is one cycle per read or write through a small register port. Read data appears on the edge after the read is issued and then holds until the next read.

Top module: `usec_timer`

## Requirements
- R1: Byte offset 0x00 selects the count register and offset 0x04 selects the prescaler setting. Any other offset reads as zero.
- R2: In the prescaler setting, bits [15:8] hold the dividend minus one and bits [7:0] hold the divisor minus one. The count advances on average dividend/divisor times per clock, and the setting reads back as written.
- R3: For whole ratios (divisor 12, 13 or 26 with dividend 1, setting 0x000B, 0x000C or 0x0019), the count advances exactly once every divisor clocks.
- R4: For setting 0x045F (dividend 5, divisor 96), the count advances exactly 50 times in any 960 consecutive clocks once the pattern has settled.
- R5: Setting 0 (dividend 1, divisor 1) advances the count on every clock.
- R6: When the dividend exceeds the divisor, the count advances once per clock and never more. The surplus stays in the accumulator.
- R7: A write to the prescaler setting clears the accumulator and leaves the count unchanged. With divisor 12, the first advance after the write lands on the 13th edge after the write edge.
- R8: Bits [31:16] of the prescaler setting read as zero, and writes to them have no effect.
- R9: Writes to the count register are ignored and leave the prescaler setting unchanged.
- R10: A read returns the count as it stood in the cycle the read was issued. The data appears on `rd_data` one edge later and holds until the next read.
- R11: The count wraps modulo 2^CNT_W, with no saturation at the top.
- R12: After reset the count is 0 and the prescaler setting is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Byte offset of the register access |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe for one cycle |
| rd_data | output | DATA_W | Registered read data |

## Verification
The bench measures tick counts over windows that are a whole number of periods of the accumulator pattern. A rate generator that drops the fractional remainder would fall short of 50 advances in 960 clocks at 5/96, and an off-by-one in the n+1 decoding would move each whole-ratio count by one. The bench rewrites the setting part way through a period and times the first advance to the exact edge, so a design that does not clear the accumulator lands early. It also runs the count through its wrap and checks the modular difference, which catches a count that saturates. Finally it writes the count register and the upper setting bits, then reads them back to show both writes had no effect.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;

   // register byte offsets
   localparam int unsigned OFS_COUNT = 32'h0000_0000;
   localparam int unsigned OFS_SCALE = 32'h0000_0004;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_COUNT = 2'd1,
      SEL_SCALE = 2'd2
   } reg_sel_e;

endpackage

// File: rtl/usec_rate_gen.sv
module usec_rate_gen #(
   parameter int FLD_W      = 8,
   parameter bit KEEP_EXCESS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [FLD_W-1:0] mul_enc,
   input  logic [FLD_W-1:0] div_enc,
   output logic             tick
);
   localparam int ACC_W = FLD_W + 2;
   localparam logic [ACC_W:0] ACC_MAX = {1'b0, {ACC_W{1'b1}}};

   if (FLD_W < 1 || FLD_W > 16) begin : g_bad_fld
      $error("usec_rate_gen: FLD_W out of range");
   end

   logic [ACC_W-1:0] acc_q, acc_d;
   logic [ACC_W:0]   step, lim, sum, rem;
   logic             hit;

   always_comb begin
      step = (ACC_W+1)'(mul_enc) + (ACC_W+1)'(1);
      lim  = (ACC_W+1)'(div_enc) + (ACC_W+1)'(1);
      sum  = {1'b0, acc_q} + step;
      hit  = (sum >= lim);
      rem  = hit ? (sum - lim) : sum;
   end

   if (KEEP_EXCESS) begin : g_keep
      // surplus is carried forward, bounded by accumulator width
      always_comb acc_d = (rem > ACC_MAX) ? ACC_MAX[ACC_W-1:0] : rem[ACC_W-1:0];
   end else begin : g_drop
      // surplus beyond one pending tick is discarded
      always_comb acc_d = (rem >= lim) ? ACC_W'(lim - (ACC_W+1)'(1)) : rem[ACC_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         tick  <= 1'b0;
      end else if (clr) begin
         acc_q <= '0;
         tick  <= 1'b0;
      end else begin
         acc_q <= acc_d;
         tick  <= hit;
      end
   end

   // R7: a setting write suppresses the pulse on the next edge
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !tick);

   // R6: dividend above divisor gives a pulse on every clock
   p_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mul_enc > div_enc && !clr) |=> tick);

endmodule

// File: rtl/usec_counter.sv
module usec_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   if (CNT_W < 2 || CNT_W > 64) begin : g_bad_cnt
      $error("usec_counter: CNT_W out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (inc) count <= count + CNT_W'(1);
   end

   // R11: the count moves by at most one per clock, modulo its width
   p_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (count == $past(count) || count == $past(count) + CNT_W'(1)));

endmodule

// File: rtl/usec_regs.sv
module usec_regs
   import usec_timer_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int FLD_W  = 8,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [CNT_W-1:0]  count,
   output logic [FLD_W-1:0]  mul_enc,
   output logic [FLD_W-1:0]  div_enc,
   output logic              scale_wr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int SCL_W = 2 * FLD_W;

   if (DATA_W < CNT_W || DATA_W < SCL_W) begin : g_bad_data
      $error("usec_regs: DATA_W too narrow");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("usec_regs: ADDR_W too narrow");
   end

   reg_sel_e          sel;
   logic [SCL_W-1:0]  scale_q;
   logic [DATA_W-1:0] cnt_ext, scl_ext, rd_mux;

   always_comb begin
      if (addr == ADDR_W'(OFS_COUNT))      sel = SEL_COUNT;
      else if (addr == ADDR_W'(OFS_SCALE)) sel = SEL_SCALE;
      else                                 sel = SEL_NONE;
   end

   assign scale_wr = wr_en && (sel == SEL_SCALE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        scale_q <= '0;
      else if (scale_wr) scale_q <= wr_data[SCL_W-1:0];
   end

   assign div_enc = scale_q[FLD_W-1:0];
   assign mul_enc = scale_q[SCL_W-1:FLD_W];

   if (DATA_W > CNT_W) begin : g_cnt_pad
      assign cnt_ext = {{(DATA_W-CNT_W){1'b0}}, count};
   end else begin : g_cnt_full
      assign cnt_ext = count;
   end

   if (DATA_W > SCL_W) begin : g_scl_pad
      assign scl_ext = {{(DATA_W-SCL_W){1'b0}}, scale_q};
   end else begin : g_scl_full
      assign scl_ext = scale_q;
   end

   always_comb begin
      unique case (sel)
         SEL_COUNT: rd_mux = cnt_ext;
         SEL_SCALE: rd_mux = scl_ext;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_mux;
   end

   // R9: a write aimed at the count leaves the setting untouched
   p_cnt_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_COUNT) |=> (scale_q == $past(scale_q)));

   if (DATA_W > SCL_W) begin : g_upper_chk
      // R8: upper setting bits read back as zero
      p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && sel == SEL_SCALE) |=> (rd_data[DATA_W-1:SCL_W] == '0));
   end

endmodule

// File: rtl/usec_timer.sv
module usec_timer #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int FLD_W       = 8,
   parameter int CNT_W       = 32,
   parameter bit KEEP_EXCESS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data
);
   logic [FLD_W-1:0] mul_enc, div_enc;
   logic             scale_wr, tick;
   logic [CNT_W-1:0] count;

   usec_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLD_W(FLD_W), .CNT_W(CNT_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_en(rd_en), .count(count),
      .mul_enc(mul_enc), .div_enc(div_enc), .scale_wr(scale_wr),
      .rd_data(rd_data)
   );

   usec_rate_gen #(
      .FLD_W(FLD_W), .KEEP_EXCESS(KEEP_EXCESS)
   ) u_rate (
      .clk(clk), .rst_n(rst_n), .clr(scale_wr),
      .mul_enc(mul_enc), .div_enc(div_enc), .tick(tick)
   );

   usec_counter #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(tick), .count(count)
   );

endmodule

// File: tb/usec_timer_bench.sv
module usec_timer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 16;
   localparam int unsigned CMASK = (1 << CNT_W) - 1;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   usec_timer #(.CNT_W(CNT_W)) u_usec_timer (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   // count advances over a window of `win` clocks after settling
   task automatic rate_case(input string req, input logic [31:0] scl,
                            input int win, input int exp_ticks);
      logic [31:0] a, b, s;
      wr(8'h04, scl);
      idle(2 * win);
      rd(8'h00, a);
      idle(win - 1);
      rd(8'h00, b);
      check(req, (b - a) & CMASK, 32'(exp_ticks));
      rd(8'h04, s);
      check("R2", s, scl & 32'h0000_FFFF);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(8'h00, d); check("R12 count", d, 32'h0);
      rd(8'h04, d); check("R12 scale", d, 32'h0);
   endtask

   task automatic t_every_clock;
      logic [31:0] a, b, h;
      rd(8'h00, a);
      rd(8'h00, b);
      check("R10 back-to-back", (b - a) & CMASK, 32'd1);
      idle(3);
      rd(8'h04, h);
      idle(2);
      check("R10 hold", rd_data, h);
      rd(8'h00, a);
      idle(49);
      rd(8'h00, b);
      check("R5", (b - a) & CMASK, 32'd50);
   endtask

   task automatic t_clear;
      logic [31:0] c0, c1, c2;
      wr(8'h04, 32'h0000_000B);
      idle(29);                    // mid-period phase
      wr(8'h04, 32'h0000_000B);
      rd(8'h00, c0);
      idle(11);
      rd(8'h00, c1);
      rd(8'h00, c2);
      check("R7 no early advance", c1, c0);
      check("R7 first advance", (c2 - c0) & CMASK, 32'd1);
   endtask

   task automatic t_upper;
      logic [31:0] d;
      wr(8'h04, 32'hABCD_0300);
      rd(8'h04, d);
      check("R8 upper", d, 32'h0000_0300);
      wr(8'h04, 32'h1234_0000);
      rd(8'h04, d);
      check("R8 upper only", d, 32'h0);
   endtask

   task automatic t_cnt_write;
      logic [31:0] a, b, s;
      wr(8'h04, 32'h0);
      idle(3);
      rd(8'h00, a);
      wr(8'h00, 32'h0000_1234);
      rd(8'h00, b);
      check("R9 count", (b - a) & CMASK, 32'd2);
      rd(8'h04, s);
      check("R9 scale", s, 32'h0);
   endtask

   task automatic t_unmapped;
      logic [31:0] d;
      rd(8'h08, d); check("R1 0x08", d, 32'h0);
      rd(8'h0C, d); check("R1 0x0C", d, 32'h0);
      rd(8'h05, d); check("R1 0x05", d, 32'h0);
   endtask

   task automatic t_wrap;
      logic [31:0] a, b;
      wr(8'h04, 32'h0);
      idle(2);
      rd(8'h00, a);
      idle(70000 - 1);
      rd(8'h00, b);
      check("R11 wrap", b, (a + 32'd70000) & CMASK);
      check("R11 diff", (b - a) & CMASK, 32'(70000 & CMASK));
   endtask

   initial begin
      idle(4);
      rst_n = 1'b1;
      t_reset();
      t_every_clock();
      rate_case("R3 div12", 32'h0000_000B, 120, 10);
      rate_case("R3 div13", 32'h0000_000C, 130, 10);
      rate_case("R3 div26", 32'h0000_0019, 260, 10);
      rate_case("R4 5/96", 32'h0000_045F, 960, 50);
      rate_case("R6 4/1", 32'h0000_0300, 50, 50);
      rate_case("R6 256/1", 32'h0000_FF00, 50, 50);
      rate_case("R6 3/2", 32'h0000_0201, 60, 60);
      t_clear();
      t_upper();
      t_cnt_write();
      t_unmapped();
      t_wrap();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule